// File: doc/BRIEF.md
# Bus-Configured Watchdog Timer

This block is a countdown watchdog. Software programs it through a small word-oriented register bus. Software selects two period codes, one for the first countdown after arming and one for every later reload. It then sets a sticky arm bit, and from then on it must write a fixed key word often enough to keep the counter from running out. Each period code picks a power-of-two cycle count. The arm bit can only be cleared by the hardware reset, so faulty software cannot switch the watchdog off.

When the count runs out, the block acts according to a response bit. In direct mode it drives a fixed-length system reset pulse. In warn-first mode the first expiry raises a level interrupt and starts a new period, and a second expiry with no valid key write in between drives the reset pulse. In both modes the counter reloads from the reload code after every expiry, so an unserviced watchdog keeps firing.

Top module: `wdog_top`

## Requirements
- R1: After reset, every register reads 0, the watchdog is unarmed, and both irq_o and sys_rst_o are low.
- R2: Register layout (byte offsets): 0x00 control, with bit 0 the arm bit and bit 1 the response bit (1 = warn first, 0 = direct reset). 0x04 periods, with bits 3:0 the reload code and bits 7:4 the initial code; upper bits are dropped and read back as 0. 0x08 is the current count (read only). 0x0C is the restart register, which always reads 0. A read returns its data one cycle after the request.
- R3: A period code c stands for 2^(BASE_EXP+c) cycles. While armed, the count drops by one every cycle.
- R4: A control write with bit 0 set, while unarmed, arms the watchdog and loads the count with the initial-code period. The first expiry is due that many cycles after the arming write.
- R5: The arm bit is sticky. A write of 0 to it while armed is ignored, and the response bit stays writable.
- R6: In direct mode each expiry drives sys_rst_o high for exactly RST_PULSE cycles and reloads the count with the reload-code period.
- R7: A restart write whose full data word equals 0x76 reloads the count with the reload-code period while armed. Any other data word, or any restart write while unarmed, leaves the count unchanged.
- R8: In warn-first mode, an expiry while irq_o is low sets irq_o and reloads the count. An expiry while irq_o is high drives the reset pulse instead.
- R9: A valid restart write clears irq_o.
- R10: Reads of any offset other than the four above return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Warning interrupt (level) |
| sys_rst_o | output | 1 | System reset pulse, active high |

## Verification
A write takes effect at the clock edge that samples it. Read data is due one cycle after the request and shows the state from before that edge. An expiry is due exactly P edges after the edge that loaded the count, where P is the loaded period. The reset pulse then stays high for RST_PULSE edges. The bench drives and samples only on falling edges and counts edges from the arming write. It checks the outputs on the edge just before each due point and on the due point itself, so a result that comes one cycle early or late is caught. The period codes are swept over a range of initial and reload values with a small BASE_EXP, and each expected value is 2^(BASE_EXP+code), worked out in the bench.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Number of bits in one period code (sixteen choices).
  localparam int SEL_W = 4;

  // Byte offsets of the mapped registers.
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_RANGE = 8'h04;
  localparam logic [7:0] OFS_COUNT = 8'h08;
  localparam logic [7:0] OFS_KICK  = 8'h0C;

  typedef struct packed {
    logic [SEL_W-1:0] init_sel;   // bits 7:4
    logic [SEL_W-1:0] run_sel;    // bits 3:0
  } range_t;

  // Cycle count selected by a period code.
  function automatic logic [63:0] wd_period(input int unsigned base_exp,
                                            input logic [SEL_W-1:0] sel);
    return 64'd1 << (base_exp + 32'(sel));
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int          ADDR_W      = 4,
  parameter int          DATA_W      = 32,
  parameter int          CNT_W       = 32,
  parameter int unsigned RESTART_KEY = 32'h76
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              armed_o,
  output logic              warn_mode_o,
  output range_t            range_o,
  output logic              arm_o,
  output logic              kick_ok_o,
  output logic              kick_bad_o
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_RANGE = ADDR_W'(OFS_RANGE);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(OFS_KICK);
  localparam logic [DATA_W-1:0] KEY_W   = DATA_W'(RESTART_KEY);
  localparam int                RANGE_W = 2 * SEL_W;

  logic        armed_q, warn_q;
  range_t      range_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic wr_ctrl, wr_range, wr_kick, rd_en, key_match;

  assign wr_ctrl   = req_i & we_i & (addr_i == A_CTRL);
  assign wr_range  = req_i & we_i & (addr_i == A_RANGE);
  assign wr_kick   = req_i & we_i & (addr_i == A_KICK);
  assign rd_en     = req_i & ~we_i;
  assign key_match = (wdata_i == KEY_W);

  // Named events for the counter, the response logic and the checker.
  assign arm_o      = wr_ctrl & wdata_i[0] & ~armed_q;
  assign kick_ok_o  = wr_kick & key_match & armed_q;
  assign kick_bad_o = wr_kick & ~key_match;

  always_comb begin
    rd_mux = '0;
    if (addr_i == A_CTRL)       rd_mux = DATA_W'({warn_q, armed_q});
    else if (addr_i == A_RANGE) rd_mux = DATA_W'(range_q);
    else if (addr_i == A_COUNT) rd_mux = DATA_W'(count_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      warn_q  <= 1'b0;
      range_q <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_ctrl) begin
        armed_q <= armed_q | wdata_i[0];
        warn_q  <= wdata_i[1];
      end
      if (wr_range) range_q <= range_t'(wdata_i[RANGE_W-1:0]);
      if (rd_en)    rdata_q <= rd_mux;
    end
  end

  assign rdata_o     = rdata_q;
  assign armed_o     = armed_q;
  assign warn_mode_o = warn_q;
  assign range_o     = range_q;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 16,
  parameter int CNT_W    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             armed_i,
  input  logic             arm_i,
  input  logic             kick_i,
  input  range_t           range_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, init_len, run_len;

  assign init_len = CNT_W'(wd_period(BASE_EXP, range_i.init_sel));
  assign run_len  = CNT_W'(wd_period(BASE_EXP, range_i.run_sel));

  // A valid restart in the expiry cycle takes priority.
  assign expire_o = armed_i & (cnt_q == ONE) & ~kick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (arm_i)             cnt_q <= init_len;
    else if (kick_i | expire_o) cnt_q <= run_len;
    else if (armed_i)           cnt_q <= cnt_q - ONE;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/wdog_resp.sv
module wdog_resp #(
  parameter int RST_PULSE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic warn_mode_i,
  input  logic kick_i,
  output logic bark_o,
  output logic bite_o,
  output logic irq_o,
  output logic sys_rst_o
);
  localparam int PW_W = $clog2(RST_PULSE + 1);
  localparam logic [PW_W-1:0] PW_LEN = PW_W'(RST_PULSE);

  logic            irq_q;
  logic [PW_W-1:0] pw_q;

  assign bark_o = expire_i & warn_mode_i & ~irq_q;
  assign bite_o = expire_i & ~bark_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      pw_q  <= '0;
    end else begin
      if (kick_i)      irq_q <= 1'b0;
      else if (bark_o) irq_q <= 1'b1;
      if (bite_o)              pw_q <= PW_LEN;
      else if (pw_q != '0)     pw_q <= pw_q - PW_W'(1);
    end
  end

  assign irq_o     = irq_q;
  assign sys_rst_o = (pw_q != '0);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int          ADDR_W      = 4,
  parameter int          DATA_W      = 32,
  parameter int          BASE_EXP    = 16,
  parameter int          RST_PULSE   = 16,
  parameter int unsigned RESTART_KEY = 32'h76
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  localparam int CNT_W = BASE_EXP + (1 << SEL_W);

  logic             armed, warn_mode, arm_ev, kick_ok, kick_bad;
  logic             expire_ev, bark_ev, bite_ev;
  range_t           range_cfg;
  logic [CNT_W-1:0] cnt_val;

  wdog_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RESTART_KEY(RESTART_KEY)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .count_i(cnt_val),
    .rdata_o(rdata_o), .armed_o(armed), .warn_mode_o(warn_mode),
    .range_o(range_cfg), .arm_o(arm_ev), .kick_ok_o(kick_ok),
    .kick_bad_o(kick_bad)
  );

  wdog_counter #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .armed_i(armed), .arm_i(arm_ev),
    .kick_i(kick_ok), .range_i(range_cfg), .count_o(cnt_val),
    .expire_o(expire_ev)
  );

  wdog_resp #(.RST_PULSE(RST_PULSE)) u_resp (
    .clk_i(clk_i), .rst_ni(rst_ni), .expire_i(expire_ev),
    .warn_mode_i(warn_mode), .kick_i(kick_ok), .bark_o(bark_ev),
    .bite_o(bite_ev), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             armed,
  input logic             arm_ev,
  input logic             kick_ok,
  input logic             kick_bad,
  input logic             expire_ev,
  input logic             bark_ev,
  input logic             bite_ev,
  input logic [CNT_W-1:0] cnt_val,
  input logic             irq_o,
  input logic             sys_rst_o
);
  a_r1_idle_when_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> (cnt_val == '0) && !irq_o && !sys_rst_o);

  a_r3_count_steps_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !arm_ev && !kick_ok && !expire_ev && (cnt_val > CNT_W'(1)))
      |=> cnt_val == $past(cnt_val) - CNT_W'(1));

  a_r4_arm_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_ev |=> armed && (cnt_val != '0));

  a_r5_arm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |=> armed);

  a_r6_bite_pulses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bite_ev |=> sys_rst_o);

  a_r7_bad_key_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_bad && !expire_ev && armed && (cnt_val > CNT_W'(1)))
      |=> cnt_val == $past(cnt_val) - CNT_W'(1));

  a_r8_bark_raises_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bark_ev |=> irq_o);

  a_r8_irq_from_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(expire_ev));

  a_r9_kick_clears_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_ok |=> !irq_o);
endmodule

bind wdog_top wdog_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .armed(armed), .arm_ev(arm_ev),
  .kick_ok(kick_ok), .kick_bad(kick_bad), .expire_ev(expire_ev),
  .bark_ev(bark_ev), .bite_ev(bite_ev), .cnt_val(cnt_val),
  .irq_o(irq_o), .sys_rst_o(sys_rst_o)
);

// File: tb/wdog_top_test.sv
module wdog_top_test;
  localparam int BASE  = 2;
  localparam int PULSE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, sys_rst;

  int n = 0, checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  wdog_top #(.ADDR_W(8), .DATA_W(32), .BASE_EXP(BASE), .RST_PULSE(PULSE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sys_rst_o(sys_rst)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp<150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic int per(input int code);
    return 1 << (BASE + code);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 1'b0; we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n = 0;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); n++;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); n++;
    v = rdata;
    req = 1'b0;
  endtask

  task automatic adv(input int upto);
    while (n < upto) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    logic [31:0] v;
    do_reset();

    // R1: reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 sys_rst", 32'(sys_rst), 0);
    bus_rd(8'h00, v); chk("R1 ctrl", v, 0);
    bus_rd(8'h04, v); chk("R1 range", v, 0);
    bus_rd(8'h08, v); chk("R1 count", v, 0);
    bus_rd(8'h0C, v); chk("R1 restart", v, 0);

    // R2, R5, R10: register behaviour
    bus_wr(8'h04, 32'hFFFF_FF37); bus_rd(8'h04, v); chk("R2 range bits", v, 32'h37);
    bus_wr(8'h00, 32'h2); bus_rd(8'h00, v); chk("R2 mode only", v, 32'h2);
    bus_wr(8'h0C, 32'h76); bus_rd(8'h08, v); chk("R7 restart unarmed", v, 0);
    bus_wr(8'h00, 32'h1); bus_rd(8'h00, v); chk("R5 armed", v, 32'h1);
    bus_wr(8'h00, 32'h0); bus_rd(8'h00, v); chk("R5 sticky arm", v, 32'h1);
    bus_wr(8'h00, 32'h2); bus_rd(8'h00, v); chk("R5 mode writable", v, 32'h3);
    bus_rd(8'h0C, v); chk("R2 restart reads 0", v, 0);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_wr(8'h05, 32'hFFFF_FFFF);
    bus_rd(8'h00, v); chk("R10 ctrl untouched", v, 32'h3);
    bus_rd(8'h04, v); chk("R10 range untouched", v, 32'h37);
    bus_rd(8'h10, v); chk("R10 unmapped read", v, 0);
    bus_rd(8'h05, v); chk("R10 misaligned read", v, 0);

    // R7: restart key
    do_reset();
    bus_wr(8'h04, 32'h21);
    bus_wr(8'h00, 32'h1); n = 0;
    bus_rd(8'h08, v); chk("R4 initial load", v, per(2));
    bus_wr(8'h0C, 32'h75);
    bus_rd(8'h08, v); chk("R7 wrong key ignored", v, per(2) - 2);
    bus_wr(8'h0C, 32'h76);
    bus_rd(8'h08, v); chk("R7 key reload", v, per(1));
    bus_wr(8'h0C, 32'h176);
    bus_rd(8'h08, v); chk("R7 full word key", v, per(1) - 2);

    // R8: warn first, then reset
    do_reset();
    bus_wr(8'h04, 32'h11);
    bus_wr(8'h00, 32'h3); n = 0;
    adv(per(1) - 1); chk("R8 irq not yet", 32'(irq), 0);
    adv(per(1));     chk("R8 irq raised", 32'(irq), 1);
    chk("R8 no reset on first", 32'(sys_rst), 0);
    adv(2 * per(1) - 1); chk("R8 no reset early", 32'(sys_rst), 0);
    adv(2 * per(1));     chk("R8 second expiry resets", 32'(sys_rst), 1);

    // R9: restart clears the warning
    do_reset();
    bus_wr(8'h04, 32'h11);
    bus_wr(8'h00, 32'h3); n = 0;
    adv(per(1)); chk("R9 irq before", 32'(irq), 1);
    bus_wr(8'h0C, 32'h76); chk("R9 irq cleared", 32'(irq), 0);
    adv(per(1) + per(1)); chk("R9 irq stays low", 32'(irq), 0);
    adv(per(1) + per(1) + 1); chk("R9 new warning", 32'(irq), 1);
    chk("R9 no reset", 32'(sys_rst), 0);

    // R3, R4, R6: sweep over initial and reload codes, direct mode
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        int pi, pj;
        pi = per(i); pj = per(j);
        do_reset();
        bus_wr(8'h04, 32'({4'(i), 4'(j)}));
        bus_wr(8'h00, 32'h1); n = 0;
        bus_rd(8'h08, v); chk("R3 count after arm", v, pi);
        adv(pi - 1); chk("R4 no reset before expiry", 32'(sys_rst), 0);
        adv(pi);     chk("R6 reset at expiry", 32'(sys_rst), 1);
        adv(pi + PULSE - 1); chk("R6 pulse held", 32'(sys_rst), 1);
        adv(pi + PULSE);     chk("R6 pulse ended", 32'(sys_rst), 0);
        adv(pi + pj - 1); chk("R3 reload gap", 32'(sys_rst), 0);
        adv(pi + pj);     chk("R6 reload period", 32'(sys_rst), 1);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule